// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache Controller

This block sits between a processor's instruction fetch port and a memory read port that can deliver bursts. Every fetch is first classified. If caching is enabled and the address lies inside a fixed, power-of-two sized, aligned address window, the fetch is cacheable. Any other fetch is forwarded to memory as a single-word read. The response is handed back without the cache storage being touched.

A cacheable address is taken relative to the window base. It is then split into a word offset within a line, a line index, and a tag made of the remaining window bits. There is a single candidate line per index. A hit returns the word one cycle after the fetch is accepted. On a miss, the whole line is requested in one burst starting at its first word. The returned words are written into storage, and the line's tag and valid flag are then set. The fetch is then replayed from the freshly loaded line.

Each stored word and tag carries an even-parity bit. A lookup that finds a parity mismatch on a valid line clears that line and refills it as if it had missed. A line can also be invalidated from outside by presenting an address. After reset, the block clears every valid flag, one index per cycle, and accepts no fetch until the sweep is done.

Top module: `icache_ctrl`

## Requirements
- R1: After reset is released, `fetch_ready` stays low for exactly LINES cycles (one per line, LINES = 16 by default) while the valid flags are swept clear. During reset and during the sweep, `rsp_valid` and `mem_req_valid` are low.
- R2: A fetch whose address lies outside [WIN_BASE, WIN_HIGH] issues one memory request with `mem_req_len` = 0 at the exact fetch address, and returns the memory word. Repeating the same fetch issues a new request, because nothing is allocated.
- R3: A cacheable fetch to a line that is not resident issues one memory request. The request address is the line base, with the low log2(LINE_WORDS)+2 bits zero. `mem_req_len` is LINE_WORDS-1, which encodes beats minus one. The request address and length stay stable until `mem_req_ready`. After the burst completes, the addressed word is returned.
- R4: A cacheable fetch to a resident line returns the correct word with `rsp_valid` high in the cycle right after the cycle in which the fetch is accepted (`fetch_valid && fetch_ready`). No memory request is made.
- R5: Two window addresses that share a line index but differ in tag evict each other. Alternating between them misses every time.
- R6: A one-cycle `inval_req` with an in-window `inval_addr` clears the line that the address indexes, so the next fetch to that line misses. An `inval_addr` outside the window has no effect.
- R7: When `par_flip` is high with a refill beat, that word is stored with a wrong parity bit. A later fetch of that word then causes a line refill through memory and returns the correct data. The other words of the line that were already loaded keep hitting until then.
- R8: With `cache_en` low at acceptance, a window fetch is served uncached (R2 shape). Lines loaded earlier remain resident and hit again once `cache_en` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cache_en | input | 1 | Caching enable, sampled when a fetch is accepted |
| inval_req | input | 1 | Invalidate the line selected by `inval_addr` |
| inval_addr | input | 32 | Byte address for line invalidation |
| fetch_valid | input | 1 | Fetch request present |
| fetch_addr | input | 32 | Fetch byte address (word aligned) |
| fetch_ready | output | 1 | Block can accept a fetch |
| rsp_valid | output | 1 | Fetched word is valid this cycle |
| rsp_data | output | 32 | Fetched instruction word |
| mem_req_valid | output | 1 | Memory read request present |
| mem_req_addr | output | 32 | Memory read start address |
| mem_req_len | output | 4 | Number of beats minus one |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Memory read beat valid |
| mem_rsp_data | input | 32 | Memory read beat data |
| mem_rsp_last | input | 1 | Final beat of the read |
| par_flip | input | 1 | Fault injection: store the current refill beat with inverted parity |

## Verification
The bench aims at addresses just outside both edges of the window. If the classification is wrong there, a foreign address is cached, or a window address goes out as a single-word read. It alternates between two tags on one index. A design that compares too few tag bits would then return a stale word without any memory request. It injects a parity fault on a word other than the one that triggered the refill, and checks both the refill and the data. A design that ignored the parity check would serve a corrupted line silently. A design that did not clear the line would spin or return stale contents. It also toggles the enable around resident lines. A design that flushed them on disable would miss where a hit is expected.

// File: rtl/icache_pkg.sv
package icache_pkg;

  typedef enum logic [2:0] {
    ST_SWEEP,
    ST_IDLE,
    ST_LOOK,
    ST_FILLREQ,
    ST_FILL,
    ST_UNREQ,
    ST_UNWAIT
  } ic_state_e;

  // Offset from the window base lies inside a window of the given size.
  function automatic logic win_hit(input logic [31:0] rel, input logic [31:0] size);
    return rel < size;
  endfunction

  // Even parity over a data word.
  function automatic logic word_par(input logic [31:0] d);
    return ^d;
  endfunction

endpackage

// File: rtl/icache_decode.sv
module icache_decode #(
  parameter logic [31:0] WIN_BASE = 32'h0001_0000,
  parameter logic [31:0] WIN_HIGH = 32'h0001_FFFF,
  parameter int          OFS_W    = 2,
  parameter int          IDX_W    = 4,
  parameter int          TAG_W    = 8
) (
  input  logic [31:0]      addr,
  input  logic             en,
  output logic             cacheable,
  output logic [IDX_W-1:0] idx,
  output logic [OFS_W-1:0] ofs,
  output logic [TAG_W-1:0] tag
);
  localparam logic [31:0] WIN_SIZE = WIN_HIGH - WIN_BASE + 32'd1;

  logic [31:0] rel;

  assign rel       = addr - WIN_BASE;
  assign cacheable = en && icache_pkg::win_hit(rel, WIN_SIZE);
  assign ofs       = rel[2 +: OFS_W];
  assign idx       = rel[2 + OFS_W +: IDX_W];
  assign tag       = rel[2 + OFS_W + IDX_W +: TAG_W];
endmodule

// File: rtl/icache_store.sv
module icache_store #(
  parameter int LINES      = 16,
  parameter int LINE_WORDS = 4,
  parameter int TAG_W      = 8,
  parameter bit PARITY_EN  = 1'b1,
  localparam int IDX_W     = $clog2(LINES),
  localparam int OFS_W     = $clog2(LINE_WORDS),
  localparam int WORDS     = LINES * LINE_WORDS
) (
  input  logic             clk,
  input  logic             rst_n,
  // clear port A: sweep or parity error
  input  logic             clr_a_en,
  input  logic [IDX_W-1:0] clr_a_idx,
  // clear port B: external invalidate
  input  logic             clr_b_en,
  input  logic [IDX_W-1:0] clr_b_idx,
  // line completion
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [TAG_W-1:0] set_tag,
  // refill beat
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [OFS_W-1:0] wr_ofs,
  input  logic [31:0]      wr_data,
  input  logic             wr_flip,
  // lookup
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [OFS_W-1:0] rd_ofs,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  output logic [31:0]      rd_data,
  output logic             rd_perr
);
  logic [32:0]      dmem [WORDS];
  logic [TAG_W:0]   tmem [LINES];
  logic [LINES-1:0] vld;
  logic [32:0]      dword;
  logic [TAG_W:0]   tword;

  always_ff @(posedge clk) begin
    if (wr_en) dmem[{wr_idx, wr_ofs}] <= {icache_pkg::word_par(wr_data) ^ wr_flip, wr_data};
    if (set_en) tmem[set_idx] <= {^set_tag, set_tag};
  end

  // clears are ordered after the set so an invalidate wins a collision
  always_ff @(posedge clk) begin
    if (set_en)   vld[set_idx]   <= 1'b1;
    if (clr_a_en) vld[clr_a_idx] <= 1'b0;
    if (clr_b_en) vld[clr_b_idx] <= 1'b0;
  end

  assign dword    = dmem[{rd_idx, rd_ofs}];
  assign tword    = tmem[rd_idx];
  assign rd_valid = vld[rd_idx];
  assign rd_data  = dword[31:0];
  assign rd_tag   = tword[TAG_W-1:0];

  generate
    if (PARITY_EN) begin : g_par
      assign rd_perr = rd_valid && ((^dword) || (^tword));
    end else begin : g_nopar
      logic unused_par_bits;
      assign unused_par_bits = dword[32] ^ tword[TAG_W];
      assign rd_perr = 1'b0;
    end
  endgenerate

  // a completed line is valid on the next cycle unless cleared with it
  assert_line_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !(clr_a_en && clr_a_idx == set_idx) && !(clr_b_en && clr_b_idx == set_idx))
      |=> vld[$past(set_idx)]);

  assert_inval_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_b_en |=> !vld[$past(clr_b_idx)]);
endmodule

// File: rtl/icache_ctrl.sv
module icache_ctrl #(
  parameter logic [31:0] WIN_BASE    = 32'h0001_0000,
  parameter logic [31:0] WIN_HIGH    = 32'h0001_FFFF,
  parameter int          CACHE_BYTES = 256,
  parameter int          LINE_WORDS  = 4,
  parameter bit          PARITY_EN   = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cache_en,
  input  logic        inval_req,
  input  logic [31:0] inval_addr,
  input  logic        fetch_valid,
  input  logic [31:0] fetch_addr,
  output logic        fetch_ready,
  output logic        rsp_valid,
  output logic [31:0] rsp_data,
  output logic        mem_req_valid,
  output logic [31:0] mem_req_addr,
  output logic [3:0]  mem_req_len,
  input  logic        mem_req_ready,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data,
  input  logic        mem_rsp_last,
  input  logic        par_flip
);
  import icache_pkg::*;

  localparam int WIN_BITS = $clog2(WIN_HIGH - WIN_BASE + 32'd1);
  localparam int CACHE_AW = $clog2(CACHE_BYTES);
  localparam int OFS_W    = $clog2(LINE_WORDS);
  localparam int IDX_W    = CACHE_AW - 2 - OFS_W;
  localparam int LINES    = 1 << IDX_W;
  localparam int TAG_W    = WIN_BITS - CACHE_AW;
  localparam int LOW_W    = OFS_W + 2;
  localparam logic [OFS_W-1:0] LAST_BEAT = OFS_W'(LINE_WORDS - 1);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(LINES - 1);

  ic_state_e        state;
  logic [31:0]      addr_q;
  logic             en_q;
  logic [OFS_W-1:0] beat_q;
  logic [IDX_W-1:0] sweep_q;

  logic             cacheable;
  logic [IDX_W-1:0] idx;
  logic [OFS_W-1:0] ofs;
  logic [TAG_W-1:0] tag;

  logic             inv_in_win;
  logic [IDX_W-1:0] inv_idx;
  logic [OFS_W-1:0] inv_ofs;
  logic [TAG_W-1:0] inv_tag;
  logic             unused_inv_bits;

  logic             rd_valid, rd_perr;
  logic [TAG_W-1:0] rd_tag;
  logic [31:0]      rd_data;

  // named events for the assertions
  logic accept, hit_evt, perr_evt, miss_evt, uncached_evt;
  logic fill_beat, fill_done, sweep_evt;

  icache_decode #(
    .WIN_BASE(WIN_BASE), .WIN_HIGH(WIN_HIGH),
    .OFS_W(OFS_W), .IDX_W(IDX_W), .TAG_W(TAG_W)
  ) i_fetch_dec (
    .addr(addr_q), .en(en_q), .cacheable(cacheable),
    .idx(idx), .ofs(ofs), .tag(tag)
  );

  icache_decode #(
    .WIN_BASE(WIN_BASE), .WIN_HIGH(WIN_HIGH),
    .OFS_W(OFS_W), .IDX_W(IDX_W), .TAG_W(TAG_W)
  ) i_inval_dec (
    .addr(inval_addr), .en(1'b1), .cacheable(inv_in_win),
    .idx(inv_idx), .ofs(inv_ofs), .tag(inv_tag)
  );

  assign unused_inv_bits = ^{inv_ofs, inv_tag};

  assign accept       = fetch_valid && fetch_ready;
  assign sweep_evt    = (state == ST_SWEEP);
  assign hit_evt      = (state == ST_LOOK) && cacheable && rd_valid && (rd_tag == tag) && !rd_perr;
  assign perr_evt     = (state == ST_LOOK) && cacheable && rd_perr;
  assign miss_evt     = (state == ST_LOOK) && cacheable && !hit_evt;
  assign uncached_evt = (state == ST_LOOK) && !cacheable;
  assign fill_beat    = (state == ST_FILL) && mem_rsp_valid;
  assign fill_done    = fill_beat && (beat_q == LAST_BEAT);

  icache_store #(
    .LINES(LINES), .LINE_WORDS(LINE_WORDS), .TAG_W(TAG_W), .PARITY_EN(PARITY_EN)
  ) i_store (
    .clk(clk), .rst_n(rst_n),
    .clr_a_en(sweep_evt || perr_evt),
    .clr_a_idx(sweep_evt ? sweep_q : idx),
    .clr_b_en(inval_req && inv_in_win && !sweep_evt),
    .clr_b_idx(inv_idx),
    .set_en(fill_done), .set_idx(idx), .set_tag(tag),
    .wr_en(fill_beat), .wr_idx(idx), .wr_ofs(beat_q),
    .wr_data(mem_rsp_data), .wr_flip(par_flip),
    .rd_idx(idx), .rd_ofs(ofs),
    .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_data(rd_data), .rd_perr(rd_perr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_SWEEP;
      addr_q  <= '0;
      en_q    <= 1'b0;
      beat_q  <= '0;
      sweep_q <= '0;
    end else begin
      unique case (state)
        ST_SWEEP: begin
          sweep_q <= sweep_q + 1'b1;
          if (sweep_q == LAST_IDX) state <= ST_IDLE;
        end
        ST_IDLE: if (accept) begin
          addr_q <= fetch_addr;
          en_q   <= cache_en;
          state  <= ST_LOOK;
        end
        ST_LOOK: begin
          if (uncached_evt)  state <= ST_UNREQ;
          else if (hit_evt)  state <= ST_IDLE;
          else               state <= ST_FILLREQ;
        end
        ST_FILLREQ: if (mem_req_ready) begin
          beat_q <= '0;
          state  <= ST_FILL;
        end
        ST_FILL: if (mem_rsp_valid) begin
          beat_q <= beat_q + 1'b1;
          if (fill_done) state <= ST_LOOK;
        end
        ST_UNREQ:  if (mem_req_ready) state <= ST_UNWAIT;
        ST_UNWAIT: if (mem_rsp_valid) state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  assign fetch_ready   = (state == ST_IDLE);
  assign rsp_valid     = hit_evt || ((state == ST_UNWAIT) && mem_rsp_valid);
  assign rsp_data      = hit_evt ? rd_data : mem_rsp_data;
  assign mem_req_valid = (state == ST_FILLREQ) || (state == ST_UNREQ);
  assign mem_req_addr  = (state == ST_FILLREQ) ? {addr_q[31:LOW_W], {LOW_W{1'b0}}} : addr_q;
  assign mem_req_len   = (state == ST_FILLREQ) ? 4'(LINE_WORDS - 1) : 4'd0;

  assert_sweep_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_evt |-> !(fetch_ready || rsp_valid || mem_req_valid));

  assert_single_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    uncached_evt |=> mem_req_valid && mem_req_len == 4'd0 && mem_req_addr == $past(addr_q));

  assert_burst_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
    miss_evt |=> mem_req_valid && mem_req_len == 4'(LINE_WORDS - 1)
                 && mem_req_addr[LOW_W-1:0] == '0);

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> mem_req_valid && $stable(mem_req_addr)
                                          && $stable(mem_req_len));

  assert_burst_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_beat |-> (mem_rsp_last == (beat_q == LAST_BEAT)));

  assert_hit_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |=> fetch_ready && !mem_req_valid);

  assert_perr_refill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    perr_evt |=> mem_req_valid && !rd_valid);
endmodule

// File: tb/test_icache_ctrl.sv
module test_icache_ctrl;
  localparam logic [31:0] BASE = 32'h0001_0000;
  localparam logic [31:0] HIGH = 32'h0001_FFFF;
  localparam int NLINES = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cache_en = 1'b1;
  logic        inval_req = 1'b0;
  logic [31:0] inval_addr = '0;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_addr = '0;
  logic        fetch_ready, rsp_valid, mem_req_valid;
  logic [31:0] rsp_data, mem_req_addr;
  logic [3:0]  mem_req_len;
  logic        mem_req_ready = 1'b1;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        mem_rsp_last = 1'b0;
  logic        par_flip = 1'b0;

  int checks = 0, fails = 0, req_count = 0, flip_next = -1;
  logic [31:0] last_req_addr = '0;
  logic [3:0]  last_req_len = '0;
  bit   done = 0;
  logic        mv [NLINES];
  logic [7:0]  mt [NLINES];

  always #4 clk = ~clk;

  icache_ctrl #(.WIN_BASE(BASE), .WIN_HIGH(HIGH), .CACHE_BYTES(256),
                .LINE_WORDS(4), .PARITY_EN(1'b1)) i_icache_ctrl (
    .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .inval_req(inval_req),
    .inval_addr(inval_addr), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .fetch_ready(fetch_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_req_len(mem_req_len), .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .mem_rsp_last(mem_rsp_last), .par_flip(par_flip));

  function automatic logic [31:0] memword(input logic [31:0] a);
    logic [31:0] w = {a[31:2], 2'b00};
    return (w ^ 32'hC3A5_5A3C) + {w[15:0], w[31:16]};
  endfunction
  function automatic bit in_win(input logic [31:0] a);
    return a >= BASE && a <= HIGH;
  endfunction
  function automatic int line_of(input logic [31:0] a);
    return int'(a[7:4]);
  endfunction
  function automatic logic [7:0] tag_of(input logic [31:0] a);
    logic [31:0] r = a - BASE;
    return r[15:8];
  endfunction

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // memory responder: one beat per cycle, driven on the falling edge
  initial begin
    int beats = 0, pos = 0, flip_at = -1;
    logic [31:0] base_a = '0;
    forever begin
      @(negedge clk);
      if (beats > 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = memword(base_a + 32'(4 * pos));
        mem_rsp_last  = (beats == 1);
        par_flip      = (pos == flip_at);
        beats--; pos++;
      end else begin
        mem_rsp_valid = 1'b0; mem_rsp_last = 1'b0; par_flip = 1'b0;
        if (mem_req_valid && mem_req_ready) begin
          req_count++;
          last_req_addr = mem_req_addr;
          last_req_len  = mem_req_len;
          base_a = mem_req_addr; beats = int'(mem_req_len) + 1; pos = 0;
          flip_at = -1;
          if (mem_req_len != 0 && flip_next >= 0) begin
            flip_at = flip_next; flip_next = -1;
          end
        end
      end
    end
  end

  task automatic do_fetch(input logic [31:0] a, output logic [31:0] d,
                          output int lat, output int reqs);
    int r0 = req_count;
    @(negedge clk);
    fetch_valid = 1'b1; fetch_addr = a;
    #1;
    while (!fetch_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    lat = 0;
    do begin
      @(negedge clk);
      if (lat == 0) fetch_valid = 1'b0;
      #1; lat++;
    end while (!rsp_valid && lat < 200);
    d = rsp_data;
    reqs = req_count - r0;
  endtask

  // 0 = uncached, 1 = miss, 2 = hit
  task automatic expect_fetch(input logic [31:0] a, input bit force_miss, input string tagname);
    logic [31:0] d; int lat, reqs, kind, li;
    string rq;
    li = line_of(a);
    if (!(cache_en && in_win(a))) kind = 0;
    else if (!force_miss && mv[li] && mt[li] == tag_of(a)) kind = 2;
    else kind = 1;
    rq = (tagname != "") ? tagname : (kind == 0 ? "R2" : kind == 1 ? "R3" : "R4");
    do_fetch(a, d, lat, reqs);
    check(d == memword(a), rq, "fetched data", d, memword(a));
    if (kind == 2) begin
      check(reqs == 0, rq, "memory requests on hit", 32'(reqs), 0);
      check(lat == 1, rq, "hit latency", 32'(lat), 1);
    end else begin
      check(reqs == 1, rq, "memory requests", 32'(reqs), 1);
      if (kind == 0) begin
        check(last_req_addr == a && last_req_len == 4'd0, rq, "single-word request addr",
              last_req_addr, a);
      end else begin
        check(last_req_addr == {a[31:4], 4'h0} && last_req_len == 4'd3, rq,
              "burst request addr", last_req_addr, {a[31:4], 4'h0});
        mv[li] = 1'b1; mt[li] = tag_of(a);
      end
    end
  endtask

  task automatic do_inval(input logic [31:0] a);
    @(negedge clk);
    inval_req = 1'b1; inval_addr = a;
    @(negedge clk);
    inval_req = 1'b0;
    if (in_win(a)) mv[line_of(a)] = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish actual=%0h expected=%0h", 0, 1);
    summary();
  end

  initial begin
    int n;
    int unsigned seed;
    seed = $urandom(32'd20240611);
    for (int i = 0; i < NLINES; i++) begin mv[i] = 1'b0; mt[i] = '0; end
    repeat (3) @(negedge clk);
    #1;
    check(!rsp_valid && !mem_req_valid, "R1", "outputs quiet in reset",
          {30'd0, rsp_valid, mem_req_valid}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    n = 0;
    while (!fetch_ready && n < 100) begin
      check(!rsp_valid && !mem_req_valid, "R1", "outputs quiet in sweep",
            {30'd0, rsp_valid, mem_req_valid}, 0);
      n++; @(negedge clk); #1;
    end
    check(n == NLINES, "R1", "sweep stall cycles", 32'(n), NLINES);

    // R3 then R4: fill a line, then hit every word
    expect_fetch(32'h0001_0024, 0, "R3");
    expect_fetch(32'h0001_0020, 0, "R4");
    expect_fetch(32'h0001_0028, 0, "R4");
    expect_fetch(32'h0001_002C, 0, "R4");
    // R2: window edges and outside addresses are never allocated
    expect_fetch(32'h0002_0000, 0, "R2");
    expect_fetch(32'h0002_0000, 0, "R2");
    expect_fetch(32'h0000_FFFC, 0, "R2");
    expect_fetch(32'h0001_FFFC, 0, "R3");
    expect_fetch(32'h0001_FFFC, 0, "R4");
    // R8: disabled fetch goes uncached, contents survive
    cache_en = 1'b0;
    expect_fetch(32'h0001_0024, 0, "R8");
    cache_en = 1'b1;
    expect_fetch(32'h0001_0024, 0, "R8");
    // R5: same index, different tag
    expect_fetch(32'h0001_0120, 0, "R5");
    expect_fetch(32'h0001_0024, 0, "R5");
    expect_fetch(32'h0001_0124, 0, "R5");
    // R6: invalidate in window, then outside the window
    do_inval(32'h0001_0128);
    expect_fetch(32'h0001_0120, 0, "R6");
    do_inval(32'h0002_0120);
    expect_fetch(32'h0001_0120, 0, "R6");
    // R7: corrupt word 2 of a fresh line
    flip_next = 2;
    expect_fetch(32'h0001_0300, 0, "R7");
    expect_fetch(32'h0001_0304, 0, "R7");
    expect_fetch(32'h0001_0308, 1, "R7");
    expect_fetch(32'h0001_0308, 0, "R7");

    // constrained random mix
    for (int k = 0; k < 400; k++) begin
      int unsigned r = $urandom();
      logic [31:0] a;
      cache_en = (r % 8) != 0;
      if ((r >> 3) % 5 == 0) a = 32'h0002_0000 + ((r >> 8) & 32'h3FC);
      else a = BASE + ((r >> 8) & 32'h7FC);
      if ((r >> 20) % 10 == 0) do_inval(BASE + (($urandom() >> 4) & 32'h7FC));
      expect_fetch(a, 0, "");
    end
    cache_en = 1'b1;
    summary();
  end
endmodule